// File: doc/BRIEF.md
# Multi-Mode Accumulating Response Compactor

This block condenses a stream of sampled test responses into a single signature for a loop-back self-test of a converter path. On every clock edge that falls inside a compaction window it adds one term to a wide accumulator. The term is picked by a 2-bit mode. It can be the stimulus word sent toward the DAC, which lets the self-test logic check itself. It can be the word read back from the ADC. It can also be the magnitude of the difference between the two, which exposes phase lag, noise and ringing. Because the result is a plain sum and not a shift-register signature, the system can accept any result inside a window of known-good values.

The stimulus word first passes through a short programmable delay of 0 to 7 cycles, so it lines up with the latency of the ADC return path. A small state machine follows the window. It has three states: `ST_IDLE` (cleared, waiting), `ST_RUN` (compacting) and `ST_HELD` (result frozen). The transitions are:
- IDLE→RUN when the enable is high.
- RUN→HELD on the first edge with the enable low.
- HELD→IDLE on a clear.
- Any state→IDLE on a clear.

While the result is held, a comparator reports whether it lies between two programmable bounds.

Top module: `resp_compactor`

## Requirements
- R1: After reset, `signature` is 0, `done` is 0 and `pass` is 0.
- R2: With `mode_sel` = 2'b01, each compacting edge adds the aligned stimulus word to the sum.
- R3: With `mode_sel` = 2'b10, each compacting edge adds the ADC word to the sum.
- R4: With `mode_sel` = 2'b11, each compacting edge adds |stimulus − ADC|. The narrower operand is zero-extended to the wider converter width before the difference is taken.
- R5: With `mode_sel` = 2'b00, compacting edges leave the sum unchanged.
- R6: A compacting edge is a rising edge with `compact_en` high, `clear` low and the block not in `ST_HELD`. The new sum appears on `signature` right after that edge. An edge with `compact_en` low in `ST_IDLE` adds nothing.
- R7: In `ST_RUN`, the first edge with `compact_en` low enters `ST_HELD`. From then on `done` is 1 and the sum stays frozen, whatever `compact_en`, `mode_sel` or the data inputs do, until a clear arrives.
- R8: An edge with `clear` high zeroes the sum and returns the block to `ST_IDLE` (`done` 0). This takes priority over compaction.
- R9: The sum wraps modulo 2^ACC_W with no saturation. ACC_W is twice the wider converter width, and at least 16.
- R10: The stimulus word used by modes 2'b01 and 2'b11 is the value `gen_word` held `align_dly` edges earlier (0 to 7). With 0, the current value is used.
- R11: `pass` is 1 exactly when `done` is 1 and `bound_lo` ≤ `signature` ≤ `bound_hi`. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_word | input | GEN_W | Stimulus word sent toward the DAC |
| adc_word | input | ADC_W | Sample read back from the ADC |
| mode_sel | input | 2 | 00 none, 01 stimulus, 10 ADC, 11 absolute difference |
| compact_en | input | 1 | Compaction window |
| clear | input | 1 | Synchronous clear of sum and state |
| align_dly | input | 3 | Stimulus alignment delay in cycles |
| bound_lo | input | ACC_W | Lower good-signature bound |
| bound_hi | input | ACC_W | Upper good-signature bound |
| signature | output | ACC_W | Accumulated sum |
| done | output | 1 | Result held |
| pass | output | 1 | Held result lies within the bounds |

## Verification
Every term reaches `signature` one edge after the cycle in which its inputs and `compact_en` are applied. `done` rises on the edge that sees `compact_en` low after a run. `pass` follows the bounds with no added latency. The stimulus tap lags `gen_word` by exactly `align_dly` edges. The bench changes inputs just after a falling edge and samples all outputs after the following falling edge, so each check falls one half-period after the rising edge that produces its value. The expected values come from hand-computed sums and from a bench-side history of the stimulus words it has driven.

// File: rtl/rc_pkg.sv
package rc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HELD = 2'd2
    } rc_state_t;

    localparam logic [1:0] MODE_NONE = 2'b00;
    localparam logic [1:0] MODE_GEN  = 2'b01;
    localparam logic [1:0] MODE_ADC  = 2'b10;
    localparam logic [1:0] MODE_DIFF = 2'b11;
endpackage

// File: rtl/rc_align.sv
module rc_align #(
    parameter int W     = 8,
    parameter int DEPTH = 7,
    parameter int SEL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     din,
    input  logic [SEL_W-1:0] sel,
    output logic [W-1:0]     dout
);
    logic [W-1:0] tap [0:DEPTH];

    assign tap[0] = din;

    for (genvar i = 1; i <= DEPTH; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tap[i] <= '0;
            else        tap[i] <= tap[i-1];
        end
    end

    assign dout = tap[sel];
endmodule

// File: rtl/rc_term.sv
module rc_term
    import rc_pkg::*;
#(
    parameter int GEN_W  = 8,
    parameter int ADC_W  = 6,
    parameter int DIFF_W = (GEN_W > ADC_W) ? GEN_W : ADC_W
) (
    input  logic [GEN_W-1:0]  gen_al,
    input  logic [ADC_W-1:0]  adc,
    input  logic [1:0]        mode,
    output logic [DIFF_W-1:0] term
);
    logic [DIFF_W-1:0] gen_x;
    logic [DIFF_W-1:0] adc_x;
    logic [DIFF_W-1:0] mag;

    assign gen_x = DIFF_W'(gen_al);
    assign adc_x = DIFF_W'(adc);
    assign mag   = (gen_x >= adc_x) ? (gen_x - adc_x) : (adc_x - gen_x);

    always_comb begin
        unique case (mode)
            MODE_GEN:  term = gen_x;
            MODE_ADC:  term = adc_x;
            MODE_DIFF: term = mag;
            default:   term = '0;
        endcase
    end
endmodule

// File: rtl/resp_compactor.sv
module resp_compactor
    import rc_pkg::*;
#(
    parameter int GEN_W     = 8,
    parameter int ADC_W     = 6,
    parameter int MAX_DLY   = 7,
    parameter int DLY_W     = $clog2(MAX_DLY + 1),
    parameter int DIFF_W    = (GEN_W > ADC_W) ? GEN_W : ADC_W,
    parameter int ACC_W     = (2 * DIFF_W < 16) ? 16 : 2 * DIFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GEN_W-1:0] gen_word,
    input  logic [ADC_W-1:0] adc_word,
    input  logic [1:0]       mode_sel,
    input  logic             compact_en,
    input  logic             clear,
    input  logic [DLY_W-1:0] align_dly,
    input  logic [ACC_W-1:0] bound_lo,
    input  logic [ACC_W-1:0] bound_hi,
    output logic [ACC_W-1:0] signature,
    output logic             done,
    output logic             pass
);
    rc_state_t         state_q, state_d;
    logic [ACC_W-1:0]  acc_q;
    logic [GEN_W-1:0]  gen_al;
    logic [DIFF_W-1:0] term;
    logic              take;

    rc_align #(.W(GEN_W), .DEPTH(MAX_DLY), .SEL_W(DLY_W)) u_align (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (gen_word),
        .sel  (align_dly),
        .dout (gen_al)
    );

    rc_term #(.GEN_W(GEN_W), .ADC_W(ADC_W), .DIFF_W(DIFF_W)) u_term (
        .gen_al(gen_al),
        .adc   (adc_word),
        .mode  (mode_sel),
        .term  (term)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (clear) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (compact_en)  state_d = ST_RUN;
                ST_RUN:  if (!compact_en) state_d = ST_HELD;
                ST_HELD: state_d = ST_HELD;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign take = compact_en && !clear && (state_q != ST_HELD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     acc_q <= '0;
        else if (clear) acc_q <= '0;
        else if (take)  acc_q <= acc_q + ACC_W'(term);
    end

    // outputs
    always_comb begin
        signature = acc_q;
        done      = (state_q == ST_HELD);
        pass      = done && (acc_q >= bound_lo) && (acc_q <= bound_hi);
    end

    assert_sum_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HELD && !clear) |=> $stable(signature));

    assert_done_after_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !$past(compact_en));

    assert_clear_zeroes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (signature == '0 && !done));

    assert_none_mode_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == MODE_NONE && !clear) |=> $stable(signature));
endmodule

// File: tb/tb_resp_compactor.sv
module tb_resp_compactor;
    localparam int GEN_W = 8;
    localparam int ADC_W = 6;
    localparam int ACC_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [GEN_W-1:0] gen_word = '0;
    logic [ADC_W-1:0] adc_word = '0;
    logic [1:0]       mode_sel = 2'b00;
    logic             compact_en = 1'b0;
    logic             clear = 1'b0;
    logic [2:0]       align_dly = 3'd0;
    logic [ACC_W-1:0] bound_lo = '0;
    logic [ACC_W-1:0] bound_hi = '1;
    logic [ACC_W-1:0] signature;
    logic             done;
    logic             pass;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    resp_compactor #(.GEN_W(GEN_W), .ADC_W(ADC_W)) dut (
        .clk(clk), .rst_n(rst_n), .gen_word(gen_word), .adc_word(adc_word),
        .mode_sel(mode_sel), .compact_en(compact_en), .clear(clear),
        .align_dly(align_dly), .bound_lo(bound_lo), .bound_hi(bound_hi),
        .signature(signature), .done(done), .pass(pass)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic sample(input int g, input int a);
        gen_word = GEN_W'(g);
        adc_word = ADC_W'(a);
        compact_en = 1'b1;
        tick();
    endtask

    task automatic end_run();
        compact_en = 1'b0;
        tick();
    endtask

    task automatic do_clear();
        clear = 1'b1;
        compact_en = 1'b0;
        tick();
        clear = 1'b0;
    endtask

    task automatic t_reset();
        check(signature == 0, "R1 sig", signature, 0);
        check(done == 0, "R1 done", done, 0);
        check(pass == 0, "R1 pass", pass, 0);
    endtask

    task automatic t_gen();
        do_clear();
        mode_sel = 2'b01; align_dly = 3'd0;
        sample(10, 7);
        check(signature == 10, "R6 first add", signature, 10);
        check(done == 0, "R6 done low in run", done, 0);
        sample(20, 7);
        sample(30, 7);
        end_run();
        check(done == 1, "R7 done", done, 1);
        check(signature == 60, "R2 gen sum", signature, 60);
    endtask

    task automatic t_adc();
        do_clear();
        mode_sel = 2'b10;
        sample(200, 63);
        sample(100, 1);
        sample(50, 17);
        end_run();
        check(signature == 81, "R3 adc sum", signature, 81);
    endtask

    task automatic t_none();
        do_clear();
        tick();
        check(signature == 0 && done == 0, "R6 idle no add", signature, 0);
        mode_sel = 2'b00;
        sample(99, 33);
        sample(77, 12);
        end_run();
        check(signature == 0, "R5 none mode", signature, 0);
        check(done == 1, "R5 done", done, 1);
    endtask

    task automatic t_diff();
        do_clear();
        mode_sel = 2'b11; align_dly = 3'd0;
        sample(5, 63);
        check(signature == 58, "R4 adc larger", signature, 58);
        sample(200, 10);
        sample(40, 40);
        end_run();
        check(signature == 248, "R4 diff sum", signature, 248);
    endtask

    task automatic t_pass();
        bound_lo = 16'd248; bound_hi = 16'd248;
        #1 check(pass == 1, "R11 inside", pass, 1);
        bound_lo = 16'd249; bound_hi = 16'd300;
        #1 check(pass == 0, "R11 below", pass, 0);
        bound_lo = 16'd0; bound_hi = 16'd247;
        #1 check(pass == 0, "R11 above", pass, 0);
        bound_lo = 16'd0; bound_hi = 16'd248;
        #1 check(pass == 1, "R11 upper edge", pass, 1);
    endtask

    task automatic t_freeze();
        mode_sel = 2'b01;
        sample(99, 5);
        sample(120, 6);
        end_run();
        check(signature == 248, "R7 frozen", signature, 248);
        check(done == 1, "R7 still done", done, 1);
    endtask

    task automatic t_clear();
        clear = 1'b1; compact_en = 1'b1; mode_sel = 2'b01; gen_word = 8'd50;
        tick();
        clear = 1'b0; compact_en = 1'b0;
        check(signature == 0, "R8 cleared", signature, 0);
        check(done == 0, "R8 done low", done, 0);
        bound_lo = 16'd0; bound_hi = '1;
        #1 check(pass == 0, "R11 not done", pass, 0);
    endtask

    task automatic t_wrap();
        do_clear();
        mode_sel = 2'b01; align_dly = 3'd0;
        for (int i = 0; i < 300; i++) sample(255, 0);
        end_run();
        check(signature == 10964, "R9 wrap", signature, 10964);
    endtask

    task automatic t_align(input int dly, input int exp);
        do_clear();
        mode_sel = 2'b01; align_dly = 3'(dly);
        for (int k = 1; k <= 9; k++) begin
            gen_word = 8'(k); compact_en = 1'b0; tick();
        end
        for (int k = 10; k <= 14; k++) sample(k, 0);
        end_run();
        check(signature == 16'(exp), "R10 align", signature, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        tick(); tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_gen();
        t_adc();
        t_none();
        t_diff();
        t_pass();
        t_freeze();
        t_clear();
        t_wrap();
        t_align(3, 45);
        t_align(0, 60);
        t_align(7, 25);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule